// File: doc/BRIEF.md
# SPI Register-Access Slave with Switchable Half-Duplex Data Line

This block connects an external SPI master to a small internal bank of byte registers. Every transfer is framed by an active-low select line. The first byte of a transfer is a command that names a register and a direction. The bytes after it are either written into consecutive registers or read out of them. The SPI pins are brought into the system clock domain through two-flop synchronizers, and edges are detected there. For this reason the system clock must run at least four times faster than SCLK. The SPI pins are a plain serial interface clocked by the master, so no valid/ready handshake applies and the master cannot be held off.

The block has two wiring modes. In full-duplex mode, data arrives on the master-out line and leaves on the master-in line, which is driven whenever the slave is selected. In half-duplex mode, the master-in line stays undriven and the master-out pin turns around: it drives read data during the data bytes of a read transfer. Each output is modelled as a data and enable pair, and the pads sit outside the block. The mode bit is itself a register written over SPI. A separate register-clear input empties the bank without touching the mode register or the serial framing logic. Only the system reset clears those.

Top module: `spi_hd_slave`

## Requirements
- R1: The first byte of a transfer is a command: bits 7:3 hold the register address, bit 1 set means write and clear means read, and bits 2 and 0 are ignored. All bytes travel most significant bit first.
- R2: In a write transfer, each completed data byte is stored in the addressed register. In a read transfer, each data byte shifted out carries the contents of the addressed register. Output bits change only after a falling SCLK edge, and input bits are taken at rising SCLK edges.
- R3: Within one transfer, the register address advances by one after every completed data byte, for both reads and writes.
- R4: While select is high, both output enables are low and SCLK edges change nothing. A transfer made after SCLK toggles while deselected behaves normally.
- R5: In full-duplex mode (mode bit 0 clear), the master-in enable is high for the whole time select is low, and the master-out enable stays low.
- R6: In half-duplex mode (register 17, bit 0 set), the master-in enable stays low. The master-out pin is driven only during the data bytes of a read transfer, and it carries the read data; it is never driven during the command byte or during write data.
- R7: A newly written mode bit takes effect only at the next rising edge of select. The transfer that writes the mode bit finishes in the old mode.
- R8: If select rises before the eighth bit of a data byte, the partial byte is dropped and no register is written.
- R9: Pulsing the register-clear input zeroes every register except register 17. It leaves the duplex mode unchanged.
- R10: After system reset, every register reads zero, the block is in full-duplex mode and both enables are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 4x SCLK |
| rst_n | input | 1 | Active-low system reset; clears everything |
| reg_clr | input | 1 | Synchronous clear of the register bank except the mode register |
| sclk | input | 1 | Serial clock from the master |
| ss_n | input | 1 | Active-low slave select |
| mosi_in | input | 1 | Level seen on the master-out pin |
| mosi_out | output | 1 | Read data driven onto the master-out pin in half-duplex mode |
| mosi_oe | output | 1 | Drive enable for the master-out pin |
| miso_out | output | 1 | Read data for the master-in pin |
| miso_oe | output | 1 | Drive enable for the master-in pin |

## Verification
The bench writes a bank of register values and reads them back. It then probes the cases a careless implementation gets wrong. A select that rises mid-byte must leave the target register untouched; a design that writes on every eight bits, or on select rise, would corrupt it. When the mode bit flips inside a transfer, the remaining bits of that transfer must stay in full-duplex mode. An early switch would release the master-in line too soon. In half-duplex mode the bench checks that the master-out pin turns around only for read data; a design that drove it during the command byte would fight the master. The last checks cover SCLK activity while deselected, which must not shift data, and the register clear, which must spare the mode bit.

// File: rtl/spi_hd_pkg.sv
package spi_hd_pkg;
  localparam int ADDR_W = 5;
  localparam int NREGS  = 1 << ADDR_W;
  localparam int BYTE_W = 8;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic              rsvd_hi;
    logic              is_write;
    logic              rsvd_lo;
  } cmd_t;
endpackage

// File: rtl/spi_hd_sync.sv
module spi_hd_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rst_val,
  input  logic async_in,
  output logic lvl,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] chain;
  logic              prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain <= {STAGES{rst_val}};
      prev  <= rst_val;
    end else begin
      chain <= {chain[STAGES-2:0], async_in};
      prev  <= chain[STAGES-1];
    end
  end

  assign lvl  = chain[STAGES-1];
  assign rise = chain[STAGES-1] & ~prev;
  assign fall = ~chain[STAGES-1] & prev;
endmodule

// File: rtl/spi_hd_regs.sv
module spi_hd_regs
  import spi_hd_pkg::*;
#(
  parameter int MODE_ADDR = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] rdata,
  output logic              half_req
);
  logic [BYTE_W-1:0] bank [NREGS];

  for (genvar i = 0; i < NREGS; i++) begin : g_reg
    localparam bit KEEP = (i == MODE_ADDR);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        bank[i] <= '0;
      end else if (we && addr == ADDR_W'(i)) begin
        bank[i] <= wdata;
      end else if (clr && !KEEP) begin
        bank[i] <= '0;
      end
    end
  end

  assign rdata    = bank[addr];
  assign half_req = bank[MODE_ADDR][0];
endmodule

// File: rtl/spi_hd_slave.sv
module spi_hd_slave
  import spi_hd_pkg::*;
#(
  parameter int MODE_ADDR = 17
) (
  input  logic clk,
  input  logic rst_n,
  input  logic reg_clr,
  input  logic sclk,
  input  logic ss_n,
  input  logic mosi_in,
  output logic mosi_out,
  output logic mosi_oe,
  output logic miso_out,
  output logic miso_oe
);
  localparam int CNT_W = $clog2(BYTE_W);

  logic sclk_lvl, sclk_rise, sclk_fall;
  logic ss_lvl, ss_rise, ss_fall;
  logic [1:0] din_sync;
  logic       sel;

  logic [CNT_W-1:0]  bit_cnt;
  logic [BYTE_W-2:0] shreg;
  logic [BYTE_W-1:0] tx;
  logic [BYTE_W-1:0] rx_byte;
  logic [ADDR_W-1:0] addr;
  logic              in_cmd;
  logic              wr_q;
  logic              half;
  logic              we;
  logic              byte_done;
  logic              half_req;
  logic [BYTE_W-1:0] rdata;
  logic [BYTE_W-1:0] load_val;
  cmd_t              cmd;

  spi_hd_sync #(.STAGES(2)) sclk_sync_i (
    .clk(clk), .rst_n(rst_n), .rst_val(1'b0), .async_in(sclk),
    .lvl(sclk_lvl), .rise(sclk_rise), .fall(sclk_fall)
  );

  spi_hd_sync #(.STAGES(2)) ss_sync_i (
    .clk(clk), .rst_n(rst_n), .rst_val(1'b1), .async_in(ss_n),
    .lvl(ss_lvl), .rise(ss_rise), .fall(ss_fall)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) din_sync <= '0;
    else        din_sync <= {din_sync[0], mosi_in};
  end

  assign sel       = ~ss_lvl;
  assign rx_byte   = {shreg, din_sync[1]};
  assign cmd       = cmd_t'(rx_byte);
  assign byte_done = sel & sclk_rise & (bit_cnt == CNT_W'(BYTE_W-1));
  assign we        = byte_done & ~in_cmd & wr_q;
  assign load_val  = (in_cmd || wr_q) ? '0 : rdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt <= '0;
      shreg   <= '0;
      tx      <= '0;
      addr    <= '0;
      in_cmd  <= 1'b1;
      wr_q    <= 1'b0;
      half    <= 1'b0;
    end else begin
      if (ss_fall) begin
        bit_cnt <= '0;
        in_cmd  <= 1'b1;
        wr_q    <= 1'b0;
        tx      <= '0;
      end else if (sel) begin
        if (sclk_rise) begin
          shreg   <= rx_byte[BYTE_W-2:0];
          bit_cnt <= bit_cnt + 1'b1;
          if (byte_done) begin
            if (in_cmd) begin
              addr   <= cmd.addr;
              wr_q   <= cmd.is_write;
              in_cmd <= 1'b0;
            end else begin
              addr <= addr + 1'b1;
            end
          end
        end
        if (sclk_fall) begin
          tx <= (bit_cnt == '0) ? load_val : {tx[BYTE_W-2:0], 1'b0};
        end
      end
      if (ss_rise) half <= half_req;
    end
  end

  spi_hd_regs #(.MODE_ADDR(MODE_ADDR)) regs_i (
    .clk(clk), .rst_n(rst_n), .clr(reg_clr), .we(we), .addr(addr),
    .wdata(rx_byte), .rdata(rdata), .half_req(half_req)
  );

  assign miso_out = tx[BYTE_W-1];
  assign mosi_out = tx[BYTE_W-1];
  assign miso_oe  = sel & ~half;
  assign mosi_oe  = sel & half & ~in_cmd & ~wr_q;

  logic unused_ok;
  assign unused_ok = sclk_lvl;
endmodule

// File: rtl/spi_hd_chk.sv
module spi_hd_chk (
  input logic clk,
  input logic rst_n,
  input logic sel,
  input logic sclk_rise,
  input logic sclk_fall,
  input logic ss_fall,
  input logic ss_rise,
  input logic we,
  input logic half,
  input logic miso_out,
  input logic miso_oe,
  input logic mosi_oe
);
  // R4
  idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |-> (!miso_oe && !mosi_oe));

  // R6
  single_driver_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(miso_oe && mosi_oe));

  // R2
  out_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sclk_fall && !ss_fall) |=> $stable(miso_out));

  // R8
  write_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> (sclk_rise && sel));

  // R7
  mode_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ss_rise |=> $stable(half));
endmodule

bind spi_hd_slave spi_hd_chk chk_i (
  .clk(clk), .rst_n(rst_n), .sel(sel), .sclk_rise(sclk_rise),
  .sclk_fall(sclk_fall), .ss_fall(ss_fall), .ss_rise(ss_rise), .we(we),
  .half(half), .miso_out(miso_out), .miso_oe(miso_oe), .mosi_oe(mosi_oe)
);

// File: tb/spi_hd_slave_tb.sv
module spi_hd_slave_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_clr = 1'b0;
  logic sclk = 1'b0;
  logic ss_n = 1'b1;
  logic tb_mosi = 1'b0;
  logic mosi_out, mosi_oe, miso_out, miso_oe;
  wire  mosi_line = mosi_oe ? mosi_out : tb_mosi;

  int n_run = 0;
  int n_fail = 0;
  logic seen_miso_oe, seen_mosi_oe;

  localparam int HALF = 8;
  localparam logic [12:0] VEC [0:5] = '{
    {5'd1, 8'hA5}, {5'd2, 8'h3C}, {5'd7, 8'hFF},
    {5'd16, 8'h81}, {5'd30, 8'h5E}, {5'd31, 8'h01}
  };

  always #2.5 clk = ~clk;

  spi_hd_slave dut_i (
    .clk(clk), .rst_n(rst_n), .reg_clr(reg_clr), .sclk(sclk), .ss_n(ss_n),
    .mosi_in(mosi_line), .mosi_out(mosi_out), .mosi_oe(mosi_oe),
    .miso_out(miso_out), .miso_oe(miso_oe)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xbits(input logic [7:0] b, input int n, output logic [7:0] r);
    r = '0;
    for (int i = 0; i < n; i++) begin
      tb_mosi = b[7-i];
      wclk(HALF);
      r = {r[6:0], (mosi_oe ? mosi_out : miso_out)};
      seen_miso_oe = miso_oe;
      seen_mosi_oe = mosi_oe;
      sclk = 1'b1;
      wclk(HALF);
      sclk = 1'b0;
    end
  endtask

  task automatic xbyte(input logic [7:0] b, output logic [7:0] r);
    xbits(b, 8, r);
  endtask

  task automatic start_x();
    ss_n = 1'b0;
    wclk(HALF);
  endtask

  task automatic stop_x();
    wclk(HALF);
    ss_n = 1'b1;
    wclk(HALF);
  endtask

  task automatic wr_reg(input logic [4:0] a, input logic [7:0] d);
    logic [7:0] r;
    start_x();
    xbyte({a, 3'b010}, r);
    xbyte(d, r);
    stop_x();
  endtask

  task automatic rd_reg(input logic [4:0] a, output logic [7:0] d);
    logic [7:0] r;
    start_x();
    xbyte({a, 3'b000}, r);
    xbyte(8'h00, d);
    stop_x();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] d, r;
    wclk(10);
    rst_n = 1'b1;
    wclk(5);

    // R10 reset state
    chk("R10 miso_oe idle", miso_oe, 0);
    chk("R10 mosi_oe idle", mosi_oe, 0);
    rd_reg(5'd3, d);
    chk("R10 reg reads zero", d, 8'h00);
    chk("R5 miso_oe while selected", seen_miso_oe, 1);
    chk("R5 mosi_oe low in full duplex", seen_mosi_oe, 0);

    // R1 R2 table walk
    foreach (VEC[k]) wr_reg(VEC[k][12:8], VEC[k][7:0]);
    foreach (VEC[k]) begin
      rd_reg(VEC[k][12:8], d);
      chk("R2 write/read back", d, {24'h0, VEC[k][7:0]});
    end

    // R1 reserved bits ignored
    start_x();
    xbyte({5'd4, 3'b111}, r);
    xbyte(8'hC3, r);
    stop_x();
    start_x();
    xbyte({5'd4, 3'b101}, r);
    xbyte(8'h00, d);
    stop_x();
    chk("R1 reserved bits ignored", d, 8'hC3);

    // R3 burst with auto-increment
    start_x();
    xbyte({5'd10, 3'b010}, r);
    xbyte(8'h11, r);
    xbyte(8'h22, r);
    xbyte(8'h33, r);
    stop_x();
    start_x();
    xbyte({5'd10, 3'b000}, r);
    xbyte(8'h00, d);
    chk("R3 burst read byte0", d, 8'h11);
    xbyte(8'h00, d);
    chk("R3 burst read byte1", d, 8'h22);
    xbyte(8'h00, d);
    chk("R3 burst read byte2", d, 8'h33);
    stop_x();

    // R8 partial byte discarded
    start_x();
    xbyte({5'd10, 3'b010}, r);
    xbits(8'hFF, 5, r);
    stop_x();
    rd_reg(5'd10, d);
    chk("R8 partial byte dropped", d, 8'h11);

    // R4 SCLK ignored while deselected
    for (int i = 0; i < 5; i++) begin
      sclk = 1'b1; wclk(HALF);
      chk("R4 oe low while deselected", {miso_oe, mosi_oe}, 0);
      sclk = 1'b0; wclk(HALF);
    end
    rd_reg(5'd11, d);
    chk("R4 transfer after idle sclk", d, 8'h22);

    // R7 mode write finishes in old mode
    start_x();
    xbyte({5'd17, 3'b010}, r);
    xbyte(8'h01, r);
    wclk(2);
    chk("R7 still full duplex before select rises", miso_oe, 1);
    stop_x();

    // R6 half-duplex read
    start_x();
    xbyte({5'd2, 3'b000}, r);
    chk("R6 no drive during command", seen_mosi_oe, 0);
    chk("R6 miso released", seen_miso_oe, 0);
    xbyte(8'h00, d);
    chk("R6 mosi driven in read data", seen_mosi_oe, 1);
    chk("R6 read data on mosi", d, 8'h3C);
    stop_x();

    // R6 half-duplex write keeps mosi as input
    start_x();
    xbyte({5'd12, 3'b010}, r);
    xbyte(8'h6D, r);
    chk("R6 no drive during write data", seen_mosi_oe, 0);
    stop_x();
    rd_reg(5'd12, d);
    chk("R6 half-duplex write stored", d, 8'h6D);

    // R9 register clear spares the mode register
    @(negedge clk); reg_clr = 1'b1;
    @(negedge clk); reg_clr = 1'b0;
    rd_reg(5'd12, d);
    chk("R9 cleared register", d, 8'h00);
    chk("R9 mode kept half duplex", seen_mosi_oe, 1);
    rd_reg(5'd17, d);
    chk("R9 mode register kept", d, 8'h01);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule